// File: doc/BRIEF.md
# Direct-Mapped Data Cache Miss Sequencer

This block controls a direct-mapped data cache that sits between a CPU load/store port and a simple word-serial memory. A request is looked up against a tag array of valid bit, dirty bit and tag per line. A hit is answered after a fixed number of cycles. A miss starts a line transfer with memory. Every transfer costs a fixed number of setup cycles, then one cycle for each 32-bit word of the line. In the write-back configuration, a miss whose victim line is valid and dirty first sends the whole victim line to memory. Only after the last word of that copy-back does the refill of the new line start.

One parameter selects the write-back or write-through policy. With write-back, a hit takes two cycles, the default line is 64 bytes, store hits mark the line dirty, and store misses allocate the line. With write-through, a hit takes one cycle, a line of 16 bytes is typical, every store is forwarded to memory as a single word write, and the cached copy is updated only on a hit. In this mode no line is ever dirty. Three counters report hits, misses and dirty misses, so the average access time can be checked against the latency formula.

The CPU raises `req_valid` and holds the request fields steady until `req_ready` pulses for one cycle. Addresses are 32-bit word addresses. In the text below, XFER = SETUP_CYCLES + words per line. With the defaults (4 setup cycles, 16 words) XFER is 20 cycles; with a 16-byte write-through line it is 8 cycles.

Top module: `cache_miss_seq`

## Requirements
- R1: After reset, every line is invalid, all three counters read zero, and `req_ready` and `mem_en` are low. The first access to any address is therefore a miss.
- R2: A hit raises `req_ready` in cycle HIT of the request, counting the first cycle `req_valid` is high as cycle 1. HIT is 2 with write-back and 1 with write-through. `req_ready` is only ever high while `req_valid` is high.
- R3: A miss with no dirty victim raises `req_ready` in cycle 1 + XFER + HIT. The refill issues exactly one read beat (`mem_en` high, `mem_we` low) per word of the line, from word 0 upward, after the setup cycles.
- R4: A load returns on `rsp_rdata`, in its `req_ready` cycle, the most recent value stored to that word address. This is either the memory word or the last CPU store.
- R5: With write-back, a store hit updates the cached word and marks the line dirty, and it issues no memory write.
- R6: With write-back, a miss on a valid dirty victim writes every word of the victim back to the victim's own addresses. All of these write beats come before the first refill read beat. `req_ready` rises in cycle 1 + 2*XFER + HIT.
- R7: A refill leaves its line clean, so evicting a refilled line that was never stored to costs no copy-back.
- R8: With write-back, a store miss refills the line, then writes the word into the cache only (memory keeps the old value). Later loads to any word of that line hit.
- R9: `hit_count` rises by one per access that hits at lookup, and `miss_count` by one per access that misses. `dirty_miss_count` rises by one per miss with a dirty victim and never exceeds `miss_count`.
- R10: With write-through, a hit completes in 1 cycle and a load miss in 1 + XFER + 1 cycles.
- R11: With write-through, every store completes in 1 cycle and issues exactly one memory write beat of the store word in its `req_ready` cycle. A store hit updates the cached word. A store miss leaves the cache contents unchanged (no allocation).
- R12: With write-through, no miss ever issues write beats, and `dirty_miss_count` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = store, 0 = load |
| req_waddr | input | WADDR_W | Word address of the access |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data, valid while `req_ready` is high |
| mem_en | output | 1 | Memory beat in this cycle |
| mem_we | output | 1 | Beat is a write (1) or read (0) |
| mem_waddr | output | WADDR_W | Word address of the beat |
| mem_wdata | output | 32 | Write beat data |
| mem_rdata | input | 32 | Read data for the current beat, same cycle |
| hit_count | output | CNT_W | Lookup hits since reset |
| miss_count | output | CNT_W | Lookup misses since reset |
| dirty_miss_count | output | CNT_W | Misses that evicted a dirty line |

## Verification
The hardest case to reach from the ports is the dirty miss: a line must first be refilled, then written by a store hit, then evicted by a load to a different tag with the same index. The bench builds this chain of three accesses on one index, counts read and write beats cycle by cycle, and flags any write beat that follows a read beat. It then reads its memory model to confirm that the stored word reached the victim's address. A second eviction of the refilled line shows that the clean state after a refill costs no copy-back.

// File: rtl/cache_seq_pkg.sv
package cache_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RESP,
        SEQ_COPY,
        SEQ_FILL
    } seq_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int NUM_LINES = 16,
    parameter int TAG_W     = 22,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag
);
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    // Valid and dirty bits are cleared by reset; tags need no reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int NUM_LINES = 16,
    parameter int WORDS     = 16,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int OFF_W    = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] idx,
    input  logic [OFF_W-1:0] rd_a_word,
    input  logic [OFF_W-1:0] rd_b_word,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_word,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_a_data,
    output logic [31:0]      rd_b_data
);
    logic [31:0] word_q [NUM_LINES*WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_q[{idx, wr_word}] <= wr_data;
        end
    end

    assign rd_a_data = word_q[{idx, rd_a_word}];
    assign rd_b_data = word_q[{idx, rd_b_word}];
endmodule

// File: rtl/cache_seq_ctrl.sv
module cache_seq_ctrl
    import cache_seq_pkg::*;
#(
    parameter bit WRITE_BACK   = 1'b1,
    parameter int WORDS        = 16,
    parameter int NUM_LINES    = 16,
    parameter int TAG_W        = 22,
    parameter int SETUP_CYCLES = 4,
    parameter int HIT_CYCLES   = 2,
    parameter int CNT_W        = 32,
    localparam int IDX_W       = $clog2(NUM_LINES),
    localparam int OFF_W       = $clog2(WORDS),
    localparam int WADDR_W     = TAG_W + IDX_W + OFF_W,
    localparam int XFER        = SETUP_CYCLES + WORDS,
    localparam int CW          = $clog2(XFER + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic [IDX_W-1:0]   req_idx,
    input  logic [OFF_W-1:0]   req_word,
    input  logic [31:0]        req_wdata,
    input  logic               line_valid,
    input  logic               line_dirty,
    input  logic [TAG_W-1:0]   line_tag,
    input  logic [31:0]        victim_data,
    input  logic [31:0]        mem_rdata,
    output logic               req_ready,
    output logic               tag_we,
    output logic               tag_wdirty,
    output logic               data_we,
    output logic [OFF_W-1:0]   data_wword,
    output logic [31:0]        data_wdata,
    output logic [OFF_W-1:0]   victim_word,
    output logic               mem_en,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_waddr,
    output logic [31:0]        mem_wdata,
    output logic [CNT_W-1:0]   hit_count,
    output logic [CNT_W-1:0]   miss_count,
    output logic [CNT_W-1:0]   dirty_miss_count
);
    localparam logic [CNT_W-1:0] CNT_ONE  = 1;
    localparam logic [CW-1:0]    CW_ONE   = 1;
    localparam logic [CW-1:0]    SETUP_CW = CW'(SETUP_CYCLES);
    localparam logic [CW-1:0]    LAST_CW  = CW'(XFER - 1);
    localparam logic [CW-1:0]    RESP_CW  = CW'(HIT_CYCLES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CW-1:0]    cnt;
        logic [CNT_W-1:0] hits;
        logic [CNT_W-1:0] misses;
        logic [CNT_W-1:0] dmiss;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic             hit;
    logic             finish;
    logic             in_beat;
    logic [CW-1:0]    rel_cnt;
    logic [OFF_W-1:0] beat_word;

    always_comb begin
        seq_d       = seq_q;
        finish      = 1'b0;
        tag_we      = 1'b0;
        tag_wdirty  = 1'b0;
        data_we     = 1'b0;
        data_wword  = req_word;
        data_wdata  = req_wdata;
        mem_en      = 1'b0;
        mem_we      = 1'b0;
        mem_waddr   = {req_tag, req_idx, req_word};
        mem_wdata   = req_wdata;
        hit         = line_valid && (line_tag == req_tag);
        rel_cnt     = seq_q.cnt - SETUP_CW;
        beat_word   = rel_cnt[OFF_W-1:0];
        in_beat     = seq_q.cnt >= SETUP_CW;
        victim_word = beat_word;

        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (req_valid) begin
                    if (hit || (!WRITE_BACK && req_write)) begin
                        if (hit) seq_d.hits = seq_q.hits + CNT_ONE;
                        else     seq_d.misses = seq_q.misses + CNT_ONE;
                        if (HIT_CYCLES == 1) begin
                            finish = 1'b1;
                        end else begin
                            seq_d.st  = SEQ_RESP;
                            seq_d.cnt = CW_ONE;
                        end
                    end else begin
                        seq_d.misses = seq_q.misses + CNT_ONE;
                        seq_d.cnt    = '0;
                        if (WRITE_BACK && line_valid && line_dirty) begin
                            seq_d.dmiss = seq_q.dmiss + CNT_ONE;
                            seq_d.st    = SEQ_COPY;
                        end else begin
                            seq_d.st = SEQ_FILL;
                        end
                    end
                end
            end
            SEQ_RESP: begin
                if (seq_q.cnt == RESP_CW) finish = 1'b1;
                else seq_d.cnt = seq_q.cnt + CW_ONE;
            end
            SEQ_COPY: begin
                if (in_beat) begin
                    mem_en    = 1'b1;
                    mem_we    = 1'b1;
                    mem_waddr = {line_tag, req_idx, beat_word};
                    mem_wdata = victim_data;
                end
                if (seq_q.cnt == LAST_CW) begin
                    seq_d.st  = SEQ_FILL;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW_ONE;
                end
            end
            SEQ_FILL: begin
                if (in_beat) begin
                    mem_en     = 1'b1;
                    mem_waddr  = {req_tag, req_idx, beat_word};
                    data_we    = 1'b1;
                    data_wword = beat_word;
                    data_wdata = mem_rdata;
                end
                if (seq_q.cnt == LAST_CW) begin
                    tag_we    = 1'b1;
                    seq_d.st  = SEQ_RESP;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW_ONE;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase

        // Completion: commit a store into the line and/or forward it to memory.
        if (finish) begin
            seq_d.st  = SEQ_IDLE;
            seq_d.cnt = '0;
            if (req_write) begin
                if (hit) begin
                    data_we = 1'b1;
                    if (WRITE_BACK) begin
                        tag_we     = 1'b1;
                        tag_wdirty = 1'b1;
                    end
                end
                if (!WRITE_BACK) begin
                    mem_en = 1'b1;
                    mem_we = 1'b1;
                end
            end
        end
        req_ready = finish;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, cnt: '0, hits: '0, misses: '0, dmiss: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign hit_count        = seq_q.hits;
    assign miss_count       = seq_q.misses;
    assign dirty_miss_count = seq_q.dmiss;
endmodule

// File: rtl/cache_miss_seq.sv
module cache_miss_seq #(
    parameter bit WRITE_BACK   = 1'b1,
    parameter int LINE_BYTES   = 64,
    parameter int NUM_LINES    = 16,
    parameter int WADDR_W      = 30,
    parameter int SETUP_CYCLES = 4,
    parameter int CNT_W        = 32,
    localparam int WORDS       = LINE_BYTES / 4,
    localparam int OFF_W       = $clog2(WORDS),
    localparam int IDX_W       = $clog2(NUM_LINES),
    localparam int TAG_W       = WADDR_W - IDX_W - OFF_W,
    localparam int HIT_CYCLES  = WRITE_BACK ? 2 : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [WADDR_W-1:0] req_waddr,
    input  logic [31:0]        req_wdata,
    output logic               req_ready,
    output logic [31:0]        rsp_rdata,
    output logic               mem_en,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_waddr,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata,
    output logic [CNT_W-1:0]   hit_count,
    output logic [CNT_W-1:0]   miss_count,
    output logic [CNT_W-1:0]   dirty_miss_count
);
    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    logic [OFF_W-1:0] req_word;
    logic             line_valid, line_dirty;
    logic [TAG_W-1:0] line_tag;
    logic             tag_we, tag_wdirty, data_we;
    logic [OFF_W-1:0] data_wword, victim_word;
    logic [31:0]      data_wdata, victim_data;

    assign req_word = req_waddr[OFF_W-1:0];
    assign req_idx  = req_waddr[OFF_W +: IDX_W];
    assign req_tag  = req_waddr[WADDR_W-1 -: TAG_W];

    cache_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (req_idx),
        .wr_en    (tag_we),
        .wr_dirty (tag_wdirty),
        .wr_tag   (req_tag),
        .rd_valid (line_valid),
        .rd_dirty (line_dirty),
        .rd_tag   (line_tag)
    );

    cache_data_store #(.NUM_LINES(NUM_LINES), .WORDS(WORDS)) u_data (
        .clk       (clk),
        .idx       (req_idx),
        .rd_a_word (req_word),
        .rd_b_word (victim_word),
        .wr_en     (data_we),
        .wr_word   (data_wword),
        .wr_data   (data_wdata),
        .rd_a_data (rsp_rdata),
        .rd_b_data (victim_data)
    );

    cache_seq_ctrl #(
        .WRITE_BACK   (WRITE_BACK),
        .WORDS        (WORDS),
        .NUM_LINES    (NUM_LINES),
        .TAG_W        (TAG_W),
        .SETUP_CYCLES (SETUP_CYCLES),
        .HIT_CYCLES   (HIT_CYCLES),
        .CNT_W        (CNT_W)
    ) u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_valid        (req_valid),
        .req_write        (req_write),
        .req_tag          (req_tag),
        .req_idx          (req_idx),
        .req_word         (req_word),
        .req_wdata        (req_wdata),
        .line_valid       (line_valid),
        .line_dirty       (line_dirty),
        .line_tag         (line_tag),
        .victim_data      (victim_data),
        .mem_rdata        (mem_rdata),
        .req_ready        (req_ready),
        .tag_we           (tag_we),
        .tag_wdirty       (tag_wdirty),
        .data_we          (data_we),
        .data_wword       (data_wword),
        .data_wdata       (data_wdata),
        .victim_word      (victim_word),
        .mem_en           (mem_en),
        .mem_we           (mem_we),
        .mem_waddr        (mem_waddr),
        .mem_wdata        (mem_wdata),
        .hit_count        (hit_count),
        .miss_count       (miss_count),
        .dirty_miss_count (dirty_miss_count)
    );
endmodule

// File: rtl/cache_seq_chk.sv
module cache_seq_chk #(
    parameter bit WRITE_BACK = 1'b1,
    parameter int CNT_W      = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             mem_en,
    input logic             mem_we,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count,
    input logic [CNT_W-1:0] dirty_miss_count
);
    localparam logic [CNT_W-1:0] ONE = 1;

    // Set by a read beat, cleared when the access completes.
    logic fill_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   fill_seen_q <= 1'b0;
        else if (req_ready)           fill_seen_q <= 1'b0;
        else if (mem_en && !mem_we)   fill_seen_q <= 1'b1;
    end

    // R2
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> req_valid);

    // R3
    mem_inside_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> req_valid);

    // R6
    copy_before_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_BACK && mem_en && mem_we) |-> !fill_seen_q);

    // R9
    hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count == $past(hit_count)) || (hit_count == $past(hit_count) + ONE));

    // R9
    dirty_le_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_miss_count <= miss_count);

    // R12
    wt_never_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !WRITE_BACK |-> (dirty_miss_count == '0));
endmodule

bind cache_miss_seq cache_seq_chk #(.WRITE_BACK(WRITE_BACK), .CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .mem_en           (mem_en),
    .mem_we           (mem_we),
    .hit_count        (hit_count),
    .miss_count       (miss_count),
    .dirty_miss_count (dirty_miss_count)
);

// File: tb/cache_miss_seq_tb.sv
module cache_miss_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Write-back instance: 64-byte lines, XFER = 20
    logic        wb_valid = 1'b0, wb_write = 1'b0;
    logic [29:0] wb_addr = '0;
    logic [31:0] wb_wdata = '0;
    logic        wb_ready, wb_men, wb_mwe;
    logic [31:0] wb_rdata, wb_mwdata, wb_mrdata;
    logic [29:0] wb_maddr;
    logic [31:0] wb_hits, wb_miss, wb_dmiss;
    logic [31:0] wb_mem [4096];

    // Write-through instance: 16-byte lines, XFER = 8
    logic        wt_valid = 1'b0, wt_write = 1'b0;
    logic [29:0] wt_addr = '0;
    logic [31:0] wt_wdata = '0;
    logic        wt_ready, wt_men, wt_mwe;
    logic [31:0] wt_rdata, wt_mwdata, wt_mrdata;
    logic [29:0] wt_maddr;
    logic [31:0] wt_hits, wt_miss, wt_dmiss;
    logic [31:0] wt_mem [4096];

    cache_miss_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(wb_valid), .req_write(wb_write),
        .req_waddr(wb_addr), .req_wdata(wb_wdata), .req_ready(wb_ready),
        .rsp_rdata(wb_rdata), .mem_en(wb_men), .mem_we(wb_mwe),
        .mem_waddr(wb_maddr), .mem_wdata(wb_mwdata), .mem_rdata(wb_mrdata),
        .hit_count(wb_hits), .miss_count(wb_miss), .dirty_miss_count(wb_dmiss)
    );

    cache_miss_seq #(.WRITE_BACK(1'b0), .LINE_BYTES(16)) u_dut_wt (
        .clk(clk), .rst_n(rst_n), .req_valid(wt_valid), .req_write(wt_write),
        .req_waddr(wt_addr), .req_wdata(wt_wdata), .req_ready(wt_ready),
        .rsp_rdata(wt_rdata), .mem_en(wt_men), .mem_we(wt_mwe),
        .mem_waddr(wt_maddr), .mem_wdata(wt_mwdata), .mem_rdata(wt_mrdata),
        .hit_count(wt_hits), .miss_count(wt_miss), .dirty_miss_count(wt_dmiss)
    );

    assign wb_mrdata = wb_mem[wb_maddr[11:0]];
    assign wt_mrdata = wt_mem[wt_maddr[11:0]];

    always @(posedge clk) begin
        if (wb_men && wb_mwe) wb_mem[wb_maddr[11:0]] <= wb_mwdata;
        if (wt_men && wt_mwe) wt_mem[wt_maddr[11:0]] <= wt_mwdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One access; counts cycles up to and including the ready cycle and
    // the memory beats seen in them. bad_order flags a write beat after a read beat.
    task automatic access(input bit wt, input bit wr, input logic [29:0] a,
                          input logic [31:0] d, output int lat, output logic [31:0] rd,
                          output int wbeats, output int rbeats, output bit bad_order);
        logic en, we, rdy;
        lat = 0; wbeats = 0; rbeats = 0; bad_order = 1'b0; rd = '0;
        @(negedge clk);
        if (wt) begin wt_valid = 1'b1; wt_write = wr; wt_addr = a; wt_wdata = d; end
        else    begin wb_valid = 1'b1; wb_write = wr; wb_addr = a; wb_wdata = d; end
        #1;
        forever begin
            lat++;
            en  = wt ? wt_men   : wb_men;
            we  = wt ? wt_mwe   : wb_mwe;
            rdy = wt ? wt_ready : wb_ready;
            if (en && we) begin
                wbeats++;
                if (rbeats > 0) bad_order = 1'b1;
            end
            if (en && !we) rbeats++;
            if (rdy) begin
                rd = wt ? wt_rdata : wb_rdata;
                break;
            end
            if (lat > 300) break;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        wb_valid = 1'b0;
        wt_valid = 1'b0;
    endtask

    int lat, wbe, rbe;
    bit bo;
    logic [31:0] rd;

    task automatic t_reset();
        chk("R1 ready low", {31'b0, wb_ready}, 32'd0);
        chk("R1 mem_en low", {31'b0, wb_men}, 32'd0);
        chk("R1 hit count", wb_hits, 32'd0);
        chk("R1 miss count", wb_miss, 32'd0);
        chk("R1 dirty count", wb_dmiss, 32'd0);
    endtask

    task automatic t_clean_miss();
        access(1'b0, 1'b0, 30'h043, '0, lat, rd, wbe, rbe, bo);
        chk("R3 clean miss latency", lat, 32'd23);
        chk("R3 refill read beats", rbe, 32'd16);
        chk("R3 no write beats", wbe, 32'd0);
        chk("R4 miss data", rd, 32'hC3000043);
        access(1'b0, 1'b0, 30'h045, '0, lat, rd, wbe, rbe, bo);
        chk("R2 wb hit latency", lat, 32'd2);
        chk("R4 hit data", rd, 32'hC3000045);
    endtask

    task automatic t_store_hit();
        access(1'b0, 1'b1, 30'h046, 32'hDEADBEEF, lat, rd, wbe, rbe, bo);
        chk("R5 store hit latency", lat, 32'd2);
        chk("R5 store hit no mem write", wbe, 32'd0);
        chk("R5 memory untouched", wb_mem[12'h046], 32'hC3000046);
        access(1'b0, 1'b0, 30'h046, '0, lat, rd, wbe, rbe, bo);
        chk("R4 load after store", rd, 32'hDEADBEEF);
    endtask

    task automatic t_dirty_miss();
        access(1'b0, 1'b0, 30'h146, '0, lat, rd, wbe, rbe, bo);
        chk("R6 dirty miss latency", lat, 32'd43);
        chk("R6 copy-back beats", wbe, 32'd16);
        chk("R6 refill beats", rbe, 32'd16);
        chk("R6 copy-back before refill", {31'b0, bo}, 32'd0);
        chk("R6 victim word in memory", wb_mem[12'h046], 32'hDEADBEEF);
        chk("R6 new line data", rd, 32'hC3000146);
    endtask

    task automatic t_clean_evict();
        access(1'b0, 1'b0, 30'h041, '0, lat, rd, wbe, rbe, bo);
        chk("R7 refilled line evicts clean", lat, 32'd23);
        chk("R7 no copy-back", wbe, 32'd0);
        chk("R4 reloaded data", rd, 32'hC3000041);
    endtask

    task automatic t_store_alloc();
        access(1'b0, 1'b1, 30'h203, 32'h12345678, lat, rd, wbe, rbe, bo);
        chk("R8 store miss latency", lat, 32'd23);
        chk("R8 store miss refill beats", rbe, 32'd16);
        chk("R8 memory keeps old value", wb_mem[12'h203], 32'hC3000203);
        access(1'b0, 1'b0, 30'h203, '0, lat, rd, wbe, rbe, bo);
        chk("R8 allocated hit latency", lat, 32'd2);
        chk("R8 allocated data", rd, 32'h12345678);
        access(1'b0, 1'b0, 30'h200, '0, lat, rd, wbe, rbe, bo);
        chk("R8 neighbour word hits", lat, 32'd2);
        chk("R8 neighbour data", rd, 32'hC3000200);
    endtask

    task automatic t_counters();
        chk("R9 hit count", wb_hits, 32'd5);
        chk("R9 miss count", wb_miss, 32'd4);
        chk("R9 dirty miss count", wb_dmiss, 32'd1);
    endtask

    task automatic t_wt();
        access(1'b1, 1'b0, 30'h010, '0, lat, rd, wbe, rbe, bo);
        chk("R10 wt miss latency", lat, 32'd10);
        chk("R10 wt refill beats", rbe, 32'd4);
        chk("R4 wt miss data", rd, 32'h7E000010);
        access(1'b1, 1'b0, 30'h013, '0, lat, rd, wbe, rbe, bo);
        chk("R10 wt hit latency", lat, 32'd1);
        access(1'b1, 1'b1, 30'h011, 32'hCAFEF00D, lat, rd, wbe, rbe, bo);
        chk("R11 store hit latency", lat, 32'd1);
        chk("R11 store hit one write beat", wbe, 32'd1);
        chk("R11 memory written", wt_mem[12'h011], 32'hCAFEF00D);
        access(1'b1, 1'b0, 30'h011, '0, lat, rd, wbe, rbe, bo);
        chk("R11 cached word updated", rd, 32'hCAFEF00D);
        access(1'b1, 1'b1, 30'h052, 32'h0BADCAFE, lat, rd, wbe, rbe, bo);
        chk("R11 store miss latency", lat, 32'd1);
        chk("R11 store miss write beat", wbe, 32'd1);
        chk("R11 store miss memory", wt_mem[12'h052], 32'h0BADCAFE);
        access(1'b1, 1'b0, 30'h011, '0, lat, rd, wbe, rbe, bo);
        chk("R11 no allocate on store miss", lat, 32'd1);
        chk("R11 old line kept", rd, 32'hCAFEF00D);
        access(1'b1, 1'b0, 30'h052, '0, lat, rd, wbe, rbe, bo);
        chk("R12 evicting written line latency", lat, 32'd10);
        chk("R12 no copy-back", wbe, 32'd0);
        chk("R12 data from memory", rd, 32'h0BADCAFE);
        chk("R12 dirty count zero", wt_dmiss, 32'd0);
        chk("R9 wt miss count", wt_miss, 32'd3);
        chk("R9 wt hit count", wt_hits, 32'd4);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            wb_mem[i] = 32'hC3000000 | i;
            wt_mem[i] = 32'h7E000000 | i;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean_miss();
        t_store_hit();
        t_dirty_miss();
        t_clean_evict();
        t_store_alloc();
        t_counters();
        t_wt();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule